// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block holds six 32-bit event counters for a processor performance monitor. Two control registers set how they count. A mode register carries three freeze bits and two overflow-enable bits. An event-select register carries an 8-bit selector for each of counters 1 to 4. A combinational decoder turns these into a per-counter choice: count retired instructions, count cycles, or hold.

On every clock, each counter that counts instructions adds the retired-instruction count (0 to `MAX_RET`). Each counter that counts cycles adds one. A counter with overflow enabled is clamped to the sign-bit threshold 0x8000_0000 when an instruction increment reaches or passes it. An overflow flag for that counter is then raised for one cycle. A cycle counter raises the flag in the cycle its value becomes the threshold. The alert logic that consumes the flags, and any freeze-on-overflow policy, sit outside this block.

Software reaches every register through one write port and one combinational read port. Address 0 is the mode register. Address 1 is the event-select register. Addresses 2 to 7 are counters 1 to 6.

Top module: `pmc_bank`

## Requirements
- R1: After reset, all six counters, the mode register and the event-select register read 0, and `ovf_vec` is 0.
- R2: Writes land at the address map: 0 = mode (5 bits), 1 = event select (32 bits), 2..7 = counters 1..6. A counter write stores only bits 31:0 of `wr_data`. A read returns the register zero-extended to 64 bits. A mode write keeps bits 4:0: bit0 freezes all, bit1 freezes counters 1-4, bit2 freezes counters 5-6, bit3 enables overflow for counter 1, and bit4 enables overflow for counters 2-5.
- R3: While mode bit0 is set, no counter changes except by a write.
- R4: Counters 1 to 4 hold while mode bit1 is set or while the event-select register is all zero.
- R5: While mode bits 0 and 2 are clear, counter 5 adds the retired count and counter 6 adds one every cycle. When bit2 is set, both hold.
- R6: The selector for counter k sits at event-select bits [8k-1:8k-8]. Counter 1 counts instructions for codes 0x02 and 0xFE, and cycles for codes 0x1E and 0xF0.
- R7: Counters 2 and 3 count instructions for code 0x02 and cycles for code 0x1E.
- R8: Counter 4 counts cycles for code 0x1E and instructions for code 0x02. For code 0xFA it counts instructions only while `run_latch` is 1.
- R9: A counter whose code is not listed for it holds its value.
- R10: When an instruction increment makes a counter's value at or above 0x8000_0000 and overflow is enabled for it, the counter becomes exactly 0x8000_0000 and its `ovf_vec` bit is 1 for the next cycle. Without the enable, the sum wraps in 32 bits and no flag rises.
- R11: A cycle-counting counter with overflow enabled raises its `ovf_vec` bit in the cycle its value becomes 0x8000_0000.
- R12: Counter 1 uses mode bit3. Counters 2 to 5 share mode bit4. Counter 6 never raises an overflow flag. `ovf_pulse` is the OR of `ovf_vec`.
- R13: A write to a counter in the same cycle as an increment stores the written value and raises no flag for that counter. A zero retired count leaves instruction counters and their flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 64 | Combinational read data |
| inst_ret | input | 4 | Instructions retired this cycle (0 to 8) |
| run_latch | input | 1 | Run-latch state, qualifies code 0xFA on counter 4 |
| ovf_vec | output | 6 | Per-counter overflow flag, bit 0 = counter 1 |
| ovf_pulse | output | 1 | OR of all overflow flags |

## Verification
A software write to a counter can land in the same cycle in which that counter, or another one, crosses the overflow threshold. The bench sets this up by preloading counters 1 and 3 just below 0x8000_0000 with both overflow enables on. It then writes counter 1 on the very clock that a three-instruction retirement arrives. The result is judged correct when counter 1 holds the written value with no flag, while counter 3 clamps to 0x8000_0000 and raises only its own flag.

// File: rtl/pmc_pkg.sv
// Package: shared sizes, register addresses, mode bit positions and event
// codes for the performance monitor counter bank.
package pmc_pkg;
    localparam int NUM_CNT  = 6;
    localparam int CNT_W    = 32;
    localparam int DATA_W   = 64;
    localparam int ADDR_W   = 3;
    localparam int MAX_RET  = 8;
    localparam int RET_W    = $clog2(MAX_RET + 1);
    localparam int SEL_W    = 8;
    localparam int NUM_SEL  = 4;                 // counters with a selector
    localparam int EVSEL_W  = NUM_SEL * SEL_W;
    localparam int MODE_W   = 5;

    // Mode register bit positions
    localparam int M_FRZ_ALL = 0;
    localparam int M_FRZ_A   = 1;                // counters 1..4
    localparam int M_FRZ_B   = 2;                // counters 5..6
    localparam int M_OVE_1   = 3;
    localparam int M_OVE_N   = 4;                // counters 2..5

    // Register addresses
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_EVSEL = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT0  = 3'd2;

    localparam logic [CNT_W-1:0] THRESH = {1'b1, {(CNT_W-1){1'b0}}};

    // Event codes
    localparam logic [SEL_W-1:0] EV_INST     = 8'h02;
    localparam logic [SEL_W-1:0] EV_CYC      = 8'h1E;
    localparam logic [SEL_W-1:0] EV_INST_ALT = 8'hFE;
    localparam logic [SEL_W-1:0] EV_CYC_ALT  = 8'hF0;
    localparam logic [SEL_W-1:0] EV_INST_RUN = 8'hFA;
endpackage

// File: rtl/pmc_ctrl_regs.sv
// Module: pmc_ctrl_regs
// Holds the mode and event-select registers and decodes counter write hits.
// Assumes a single write port; addresses past the last counter are ignored.
module pmc_ctrl_regs
    import pmc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [MODE_W-1:0]   mode_q,
    output logic [EVSEL_W-1:0]  evsel_q,
    output logic [NUM_CNT-1:0]  cnt_wr_hit,
    output logic [CNT_W-1:0]    cnt_wr_val
);
    logic wr_data_unused;
    assign wr_data_unused = ^wr_data[DATA_W-1:CNT_W];

    // Control register storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            evsel_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_MODE)  mode_q  <= wr_data[MODE_W-1:0];
            if (wr_addr == A_EVSEL) evsel_q <= wr_data[EVSEL_W-1:0];
        end
    end

    // Per-counter write hit decode
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_hit
        assign cnt_wr_hit[k] = wr_en && (wr_addr == A_CNT0 + ADDR_W'(k));
    end

    assign cnt_wr_val = wr_data[CNT_W-1:0];
endmodule

// File: rtl/pmc_cfg_decode.sv
// Module: pmc_cfg_decode
// Turns freeze bits and event selectors into per-counter instruction and
// cycle enables. Assumes the two enables are never both set for a counter.
module pmc_cfg_decode
    import pmc_pkg::*;
(
    input  logic                frz_all,
    input  logic                frz_a,
    input  logic                frz_b,
    input  logic [EVSEL_W-1:0]  evsel,
    input  logic                run_latch,
    output logic [NUM_CNT-1:0]  inst_en,
    output logic [NUM_CNT-1:0]  cyc_en
);
    logic grp_a_on;
    logic grp_b_on;
    logic [SEL_W-1:0] code [NUM_SEL];

    assign grp_a_on = !frz_all && !frz_a && (evsel != '0);
    assign grp_b_on = !frz_all && !frz_b;

    for (genvar k = 0; k < NUM_SEL; k++) begin : g_code
        assign code[k] = evsel[k*SEL_W +: SEL_W];
    end

    // Event-code decode per counter
    always_comb begin
        inst_en = '0;
        cyc_en  = '0;
        inst_en[0] = grp_a_on && (code[0] == EV_INST || code[0] == EV_INST_ALT);
        cyc_en[0]  = grp_a_on && (code[0] == EV_CYC  || code[0] == EV_CYC_ALT);
        for (int k = 1; k < 3; k++) begin
            inst_en[k] = grp_a_on && (code[k] == EV_INST);
            cyc_en[k]  = grp_a_on && (code[k] == EV_CYC);
        end
        inst_en[3] = grp_a_on && (code[3] == EV_INST ||
                                  (code[3] == EV_INST_RUN && run_latch));
        cyc_en[3]  = grp_a_on && (code[3] == EV_CYC);
        inst_en[4] = grp_b_on;
        cyc_en[5]  = grp_b_on;
    end
endmodule

// File: rtl/pmc_counter.sv
// Module: pmc_counter
// One event counter: write, instruction add with threshold clamp, or cycle
// add with threshold flag. Assumes inst_cnt never exceeds MAX_RET.
module pmc_counter
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [CNT_W-1:0]  wr_val,
    input  logic              inst_en,
    input  logic              cyc_en,
    input  logic              ovf_en,
    input  logic [RET_W-1:0]  inst_cnt,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              ovf_q
);
    logic [CNT_W:0]   inst_sum;
    logic [CNT_W-1:0] cyc_sum;
    logic             inst_hit;

    assign inst_sum = {1'b0, cnt_q} + {{(CNT_W+1-RET_W){1'b0}}, inst_cnt};
    assign cyc_sum  = cnt_q + 1'b1;
    assign inst_hit = ovf_en && (inst_sum >= {1'b0, THRESH});

    // Counter value and overflow flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (wr_hit) begin
            cnt_q <= wr_val;
            ovf_q <= 1'b0;
        end else if (inst_en && inst_cnt != '0) begin
            cnt_q <= inst_hit ? THRESH : inst_sum[CNT_W-1:0];
            ovf_q <= inst_hit;
        end else if (cyc_en) begin
            cnt_q <= cyc_sum;
            ovf_q <= ovf_en && (cyc_sum == THRESH);
        end else begin
            ovf_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pmc_bank.sv
// Module: pmc_bank
// Top of the performance monitor counter bank: control registers, decoder,
// six counters and the read mux. Assumes one register access per cycle.
module pmc_bank
    import pmc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [RET_W-1:0]    inst_ret,
    input  logic                run_latch,
    output logic [NUM_CNT-1:0]  ovf_vec,
    output logic                ovf_pulse
);
    logic [MODE_W-1:0]        mode_q;
    logic [EVSEL_W-1:0]       evsel_q;
    logic [NUM_CNT-1:0]       cnt_wr_hit;
    logic [CNT_W-1:0]         cnt_wr_val;
    logic [NUM_CNT-1:0]       inst_en;
    logic [NUM_CNT-1:0]       cyc_en;
    logic [NUM_CNT-1:0]       ovf_en;
    logic [CNT_W-1:0]         cnt_q [NUM_CNT];
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;

    pmc_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .mode_q     (mode_q),
        .evsel_q    (evsel_q),
        .cnt_wr_hit (cnt_wr_hit),
        .cnt_wr_val (cnt_wr_val)
    );

    pmc_cfg_decode u_dec (
        .frz_all   (mode_q[M_FRZ_ALL]),
        .frz_a     (mode_q[M_FRZ_A]),
        .frz_b     (mode_q[M_FRZ_B]),
        .evsel     (evsel_q),
        .run_latch (run_latch),
        .inst_en   (inst_en),
        .cyc_en    (cyc_en)
    );

    // Overflow enable mapping: own bit, shared bit, or none
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        if (k == 0) begin : g_own
            assign ovf_en[k] = mode_q[M_OVE_1];
        end else if (k < NUM_CNT - 1) begin : g_shr
            assign ovf_en[k] = mode_q[M_OVE_N];
        end else begin : g_none
            assign ovf_en[k] = 1'b0;
        end

        pmc_counter u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (cnt_wr_hit[k]),
            .wr_val   (cnt_wr_val),
            .inst_en  (inst_en[k]),
            .cyc_en   (cyc_en[k]),
            .ovf_en   (ovf_en[k]),
            .inst_cnt (inst_ret),
            .cnt_q    (cnt_q[k]),
            .ovf_q    (ovf_vec[k])
        );

        assign cnt_flat[k*CNT_W +: CNT_W] = cnt_q[k];
    end

    assign ovf_pulse = |ovf_vec;

    // Combinational read mux, zero-extended
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_MODE) begin
            rd_data[MODE_W-1:0] = mode_q;
        end else if (rd_addr == A_EVSEL) begin
            rd_data[EVSEL_W-1:0] = evsel_q;
        end else begin
            for (int k = 0; k < NUM_CNT; k++) begin
                if (rd_addr == A_CNT0 + ADDR_W'(k)) rd_data[CNT_W-1:0] = cnt_q[k];
            end
        end
    end
endmodule

// File: rtl/pmc_bank_chk.sv
// Module: pmc_bank_chk
// Property checker for pmc_bank, attached through bind.
module pmc_bank_chk
    import pmc_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [CNT_W-1:0]         wr_low,
    input logic [MODE_W-1:0]        mode_q,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
    input logic [NUM_CNT-1:0]       ovf_vec,
    input logic [NUM_CNT-1:0]       inst_en,
    input logic [NUM_CNT-1:0]       cyc_en,
    input logic [NUM_CNT-1:0]       cnt_wr_hit
);
    AST_FREEZE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[M_FRZ_ALL] && !wr_en) |=> $stable(cnt_flat)); // R3

    AST_OVF_EN_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_vec[0] |-> $past(mode_q[M_OVE_1])); // R12

    AST_OVF_EN_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf_vec[NUM_CNT-2:1]) |-> $past(mode_q[M_OVE_N])); // R12

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
        AST_OVF_AT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_vec[k] |-> (cnt_flat[k*CNT_W +: CNT_W] == THRESH)); // R10

        AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_wr_hit[k] |=> (cnt_flat[k*CNT_W +: CNT_W] == $past(wr_low)) && !ovf_vec[k]); // R13

        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!inst_en[k] && !cyc_en[k] && !cnt_wr_hit[k])
            |=> $stable(cnt_flat[k*CNT_W +: CNT_W])); // R9
    end
endmodule

bind pmc_bank pmc_bank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_low     (wr_data[31:0]),
    .mode_q     (mode_q),
    .cnt_flat   (cnt_flat),
    .ovf_vec    (ovf_vec),
    .inst_en    (inst_en),
    .cyc_en     (cyc_en),
    .cnt_wr_hit (cnt_wr_hit)
);

// File: tb/pmc_bank_tb.sv
`timescale 1ns/100ps
module pmc_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic [3:0]  inst_ret = '0;
    logic        run_latch = 1'b0;
    logic [5:0]  ovf_vec;
    logic        ovf_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pmc_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .inst_ret(inst_ret), .run_latch(run_latch),
        .ovf_vec(ovf_vec), .ovf_pulse(ovf_pulse)
    );

    // Vector: mode, event select, run latch, retired count, deltas c6..c1
    typedef struct packed {
        logic [4:0]      mode;
        logic [31:0]     evsel;
        logic            run;
        logic [3:0]      inst;
        logic [5:0][7:0] dlt;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'h00, 32'h0000_0000, 1'b0, 4'd3, {8'd1,8'd3,8'd0,8'd0,8'd0,8'd0}}, // R4 R5
        '{5'h00, 32'h1E02_1E02, 1'b0, 4'd3, {8'd1,8'd3,8'd1,8'd3,8'd1,8'd3}}, // R6 R7 R8
        '{5'h00, 32'h021E_02FE, 1'b0, 4'd3, {8'd1,8'd3,8'd3,8'd1,8'd3,8'd3}}, // R6 R7 R8
        '{5'h00, 32'hFAF0_FEF0, 1'b0, 4'd3, {8'd1,8'd3,8'd0,8'd0,8'd0,8'd1}}, // R8 R9
        '{5'h00, 32'hFAF0_FEF0, 1'b1, 4'd3, {8'd1,8'd3,8'd3,8'd0,8'd0,8'd1}}, // R8
        '{5'h02, 32'h1E02_1E02, 1'b0, 4'd3, {8'd1,8'd3,8'd0,8'd0,8'd0,8'd0}}, // R4
        '{5'h04, 32'h1E02_1E02, 1'b0, 4'd3, {8'd0,8'd0,8'd1,8'd3,8'd1,8'd3}}, // R5
        '{5'h01, 32'h1E02_1E02, 1'b0, 4'd3, {8'd0,8'd0,8'd0,8'd0,8'd0,8'd0}}, // R3
        '{5'h00, 32'hFEFA_0055, 1'b0, 4'd5, {8'd1,8'd5,8'd0,8'd0,8'd0,8'd0}}, // R9
        '{5'h00, 32'h1E02_1E02, 1'b0, 4'd0, {8'd1,8'd0,8'd1,8'd0,8'd1,8'd0}}  // R13
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [63:0] exp);
        rd_addr = a;
        #0.1;
        chk(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #0.5 wr_en = 1'b0;
    endtask

    // One counting cycle; the same edge loads the freeze mode given
    task automatic count_once(input logic [3:0] n, input logic run, input logic [4:0] frz);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = {59'd0, frz};
        inst_ret = n; run_latch = run;
        @(posedge clk);
        #0.5;
        wr_en = 1'b0; inst_ret = '0; run_latch = 1'b0;
    endtask

    task automatic preset(input logic [4:0] frz, input logic [31:0] ev);
        wr(3'd0, {59'd0, frz});
        wr(3'd1, {32'd0, ev});
        for (int k = 0; k < 6; k++) wr(3'(2 + k), 64'd0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) chk_reg("R1 reg after reset", 3'(a), 64'd0);
        chk("R1 ovf after reset", {58'd0, ovf_vec}, 64'd0);

        // R2: width masking on writes
        wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        chk_reg("R2 mode keeps 5 bits", 3'd0, 64'h1F);
        wr(3'd3, 64'hDEAD_BEEF_1234_5678);
        chk_reg("R2 counter keeps low 32", 3'd3, 64'h1234_5678);
        wr(3'd1, 64'hAAAA_BBBB_CCCC_DDDD);
        chk_reg("R2 evsel keeps 32", 3'd1, 64'hCCCC_DDDD);

        // Vector table: one counting cycle per entry
        for (int v = 0; v < NV; v++) begin
            preset(5'h01, VECS[v].evsel);
            wr(3'd0, {59'd0, VECS[v].mode});
            count_once(VECS[v].inst, VECS[v].run, 5'h01);
            for (int k = 0; k < 6; k++)
                chk_reg($sformatf("R3-R9 vec%0d c%0d", v, k + 1), 3'(2 + k),
                        {56'd0, VECS[v].dlt[k]});
        end

        // R10: clamp with enable on counter 1
        preset(5'h09, 32'h0000_0002);
        wr(3'd2, 64'h7FFF_FFFE);
        wr(3'd0, 64'h08);
        count_once(4'd5, 1'b0, 5'h09);
        chk("R10 ovf_vec clamp", {58'd0, ovf_vec}, 64'h01);
        chk("R12 ovf_pulse", {63'd0, ovf_pulse}, 64'd1);
        chk_reg("R10 c1 clamped", 3'd2, 64'h8000_0000);

        // R10: no enable, wrap past threshold without flag
        preset(5'h01, 32'h0000_0002);
        wr(3'd2, 64'h7FFF_FFFE);
        wr(3'd0, 64'h00);
        count_once(4'd5, 1'b0, 5'h01);
        chk("R10 no flag without enable", {58'd0, ovf_vec}, 64'd0);
        chk_reg("R10 c1 plain sum", 3'd2, 64'h8000_0003);

        // R12: shared enable on c2 and c5, none on c1 and c6
        preset(5'h11, 32'h0000_0202);
        wr(3'd2, 64'h7FFF_FFFF);
        wr(3'd3, 64'h7FFF_FFFF);
        wr(3'd6, 64'h7FFF_FFFD);
        wr(3'd7, 64'h7FFF_FFFF);
        wr(3'd0, 64'h10);
        count_once(4'd3, 1'b0, 5'h11);
        chk("R12 flags c2 c5 only", {58'd0, ovf_vec}, 64'h12);
        chk_reg("R12 c1 wraps", 3'd2, 64'h8000_0002);
        chk_reg("R12 c2 clamped", 3'd3, 64'h8000_0000);
        chk_reg("R12 c5 clamped", 3'd6, 64'h8000_0000);
        chk_reg("R12 c6 reaches no flag", 3'd7, 64'h8000_0000);

        // R11: cycle counter flags on reaching threshold
        preset(5'h0D, 32'h0000_001E);
        wr(3'd2, 64'h7FFF_FFFF);
        wr(3'd0, 64'h0C);
        count_once(4'd0, 1'b0, 5'h0D);
        chk("R11 cycle flag", {58'd0, ovf_vec}, 64'h01);
        chk_reg("R11 c1 value", 3'd2, 64'h8000_0000);

        // R13: write collides with increment; another counter overflows
        preset(5'h1D, 32'h1E02_1E02);
        wr(3'd2, 64'h7FFF_FFFF);
        wr(3'd4, 64'h7FFF_FFFF);
        wr(3'd0, 64'h1C);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 64'd100; inst_ret = 4'd3;
        @(posedge clk);
        #0.5;
        wr_en = 1'b0; inst_ret = '0;
        chk("R13 only c3 flags", {58'd0, ovf_vec}, 64'h04);
        chk_reg("R13 write wins on c1", 3'd2, 64'd100);
        chk_reg("R13 c3 clamped same cycle", 3'd4, 64'h8000_0000);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule